// File: doc/BRIEF.md
# Block Copy DMA Engine

This block copies a run of bytes between host memory and a 4096-byte on-device buffer. The buffer is mapped at device address 0x40000. Software writes a source address, a destination address and a byte count into 64-bit registers. It then writes a command word holding a go bit, a direction bit and an interrupt-enable bit. The address that falls in the device window picks the buffer location, and the other address is sent to the host-memory port.

The engine moves one byte for each request/acknowledge handshake on the host-memory port. It reads and writes the buffer through a direct port with combinational read data. The go bit stays set while the copy runs, so software can poll it as a busy flag. When the copy ends, the go bit clears and, if enabled, a one-cycle completion interrupt pulse is raised; this pulse stands for status value 0x100. Host addresses are cut to a parameterised width, 28 bits by default.

Top module: `blkdma_engine`

## Requirements
- R1: After reset the registers at 0x80, 0x88, 0x90 and 0x98 read zero, mem_req is low and done_irq is low.
- R2: The registers are source address at 0x80, destination address at 0x88, byte count at 0x90 and command at 0x98. An 8-byte access (reg_wide=1) at one of these offsets reaches the whole register. A 4-byte access at offset +0 or +4 reaches the low or high half, returned in reg_rdata[31:0] with the upper bits zero. A 4-byte write leaves the other half unchanged. The command reads back only bits [2:0].
- R3: Accesses are ignored, and reads return zero, in three cases: an 8-byte access at an offset whose bit 2 is set, an offset not a multiple of 4, and any offset below 0x80.
- R4: With command bit 1 clear, count bytes are copied from host address src to the buffer at byte dst-0x40000, in ascending order.
- R5: With command bit 1 set, count bytes are copied from the buffer at byte src-0x40000 to host address dst, in ascending order.
- R6: Command bit 0 (value 0x01) starts a copy and reads 1 from the writing cycle until completion. At completion, src and dst have each advanced by the count and the count reads zero.
- R7: If command bit 2 (value 0x04) is set, done_irq pulses high for exactly one cycle when the copy completes. If it is clear, no pulse appears.
- R8: Each cycle with mem_req and mem_ack both high moves exactly one byte. While mem_req is high without mem_ack, mem_addr and mem_we hold steady.
- R9: mem_addr carries the low HOST_AW (default 28) bits of the host-side address. Higher address bits are dropped.
- R10: A copy is aborted in two cases: the device-side address is below 0x40000, or the device-side address plus count exceeds 0x41000. An aborted copy makes no host request and no buffer write, clears bit 0, leaves the address and count registers unchanged and raises no interrupt. A range ending exactly at 0x41000 is legal.
- R11: Register writes made while a copy is active have no effect.
- R12: A copy with count zero completes without any host request and raises done_irq if bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wide | input | 1 | 1: 8-byte access, 0: 4-byte access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Host-memory request |
| mem_we | output | 1 | Host-memory write (1) or read (0) |
| mem_addr | output | HOST_AW | Host byte address |
| mem_wdata | output | 8 | Host write byte |
| mem_ack | input | 1 | Host-memory acknowledge, completes one byte |
| mem_rdata | input | 8 | Host read byte, valid with mem_ack |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 12 | Buffer byte index |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte for buf_addr |
| done_irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The hardest case to reach from the ports is a register write that arrives in the middle of a copy. The write must change nothing, even though the copy itself keeps rewriting the same address and count registers. The bench reaches this case by holding mem_ack low, so the engine stalls partway through. While it is stalled, the bench rewrites the count, the addresses and the command. After releasing the acknowledge, it checks that the original copy finished unchanged. Random acknowledge gaps, random lengths, random directions and random window placements cover the rest. Directed cases hit both window edges and a host address above the 28-bit limit.

// File: rtl/blkdma_engine.sv
module blkdma_engine #(
  parameter int          HOST_AW   = 28,
  parameter logic [63:0] WIN_BASE  = 64'h4_0000,
  parameter int          WIN_BYTES = 4096
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [7:0]                   reg_addr,
  input  logic                         reg_wide,
  input  logic [63:0]                  reg_wdata,
  output logic [63:0]                  reg_rdata,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [HOST_AW-1:0]           mem_addr,
  output logic [7:0]                   mem_wdata,
  input  logic                         mem_ack,
  input  logic [7:0]                   mem_rdata,
  output logic                         buf_we,
  output logic [$clog2(WIN_BYTES)-1:0] buf_addr,
  output logic [7:0]                   buf_wdata,
  input  logic [7:0]                   buf_rdata,
  output logic                         done_irq
);
  localparam int          BW      = $clog2(WIN_BYTES);
  localparam logic [64:0] WIN_END = {1'b0, WIN_BASE} + 65'(WIN_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_RUN} st_t;

  st_t         st;
  logic [63:0] src_q, dst_q, cnt_q;
  logic [2:0]  cmd_q;

  wire busy   = (st != S_IDLE);
  wire legal  = (reg_addr[7:5] == 3'b100) && (reg_addr[1:0] == 2'b00) &&
                !(reg_wide && reg_addr[2]);
  wire wr_ok  = reg_wr && legal && !busy;
  wire [1:0] sel = reg_addr[4:3];

  logic [63:0] cur;
  always_comb begin
    case (sel)
      2'd0:    cur = src_q;
      2'd1:    cur = dst_q;
      2'd2:    cur = cnt_q;
      default: cur = {61'd0, cmd_q};
    endcase
  end

  wire [63:0] merged = reg_wide   ? reg_wdata :
                       reg_addr[2] ? {reg_wdata[31:0], cur[31:0]} :
                                     {cur[63:32], reg_wdata[31:0]};

  assign reg_rdata = !legal     ? 64'd0 :
                     reg_wide    ? cur :
                     reg_addr[2] ? {32'd0, cur[63:32]} : {32'd0, cur[31:0]};

  wire [63:0] dev_a  = cmd_q[1] ? src_q : dst_q;
  wire [63:0] host_a = cmd_q[1] ? dst_q : src_q;
  wire [64:0] dev_e  = {1'b0, dev_a} + {1'b0, cnt_q};
  wire        in_win = (dev_a >= WIN_BASE) && (dev_e <= WIN_END);
  wire [63:0] dev_off = dev_a - WIN_BASE;

  assign mem_req   = (st == S_RUN);
  assign mem_we    = cmd_q[1];
  assign mem_addr  = host_a[HOST_AW-1:0];
  assign mem_wdata = buf_rdata;
  assign buf_addr  = dev_off[BW-1:0];
  assign buf_wdata = mem_rdata;
  assign buf_we    = mem_req && mem_ack && !cmd_q[1];

  wire step = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      cmd_q    <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      case (st)
        S_IDLE: if (wr_ok) begin
          case (sel)
            2'd0:    src_q <= merged;
            2'd1:    dst_q <= merged;
            2'd2:    cnt_q <= merged;
            default: begin
              cmd_q <= merged[2:0];
              if (merged[0]) st <= S_CHK;
            end
          endcase
        end
        S_CHK: begin
          if (!in_win) begin
            cmd_q[0] <= 1'b0;
            st       <= S_IDLE;
          end else if (cnt_q == 64'd0) begin
            cmd_q[0] <= 1'b0;
            st       <= S_IDLE;
            done_irq <= cmd_q[2];
          end else begin
            st <= S_RUN;
          end
        end
        default: if (step) begin
          src_q <= src_q + 64'd1;
          dst_q <= dst_q + 64'd1;
          cnt_q <= cnt_q - 64'd1;
          if (cnt_q == 64'd1) begin
            cmd_q[0] <= 1'b0;
            st       <= S_IDLE;
            done_irq <= cmd_q[2];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/blkdma_engine_chk.sv
module blkdma_engine_chk #(
  parameter int HOST_AW = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               mem_req,
  input logic               mem_ack,
  input logic               mem_we,
  input logic [HOST_AW-1:0] mem_addr,
  input logic               buf_we,
  input logic               done_irq,
  input logic [63:0]        cnt_q
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r4_buf_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> mem_req && mem_ack && !mem_we);

  a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !buf_we);

  a_r11_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(mem_req && mem_ack) |=> $stable(cnt_q));
endmodule

bind blkdma_engine blkdma_engine_chk #(.HOST_AW(HOST_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_addr(mem_addr), .buf_we(buf_we), .done_irq(done_irq),
  .cnt_q(cnt_q)
);

// File: tb/blkdma_engine_test.sv
module blkdma_engine_test;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_wide = 1'b1;
  logic [7:0]  reg_addr = 8'h0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [27:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, buf_wdata, buf_rdata;
  logic        buf_we, done_irq;
  logic [11:0] buf_addr;

  logic [7:0] hmem [0:65535];
  logic [7:0] bmem [0:4095];
  logic [7:0] ehost [0:65535];
  logic [7:0] ebuf [0:4095];

  int ncheck = 0, nfail = 0, nacc = 0, nirq = 0, nhold = 0;
  bit stall = 1'b0, prev_pend = 1'b0;
  logic [27:0] prev_a = '0, last_ma = '0;

  always #4 clk = ~clk;

  blkdma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wide(reg_wide),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .done_irq(done_irq));

  assign mem_rdata = hmem[mem_addr[15:0]];
  assign buf_rdata = bmem[buf_addr];

  always @(negedge clk) mem_ack = mem_req && !stall && ($urandom % 3 != 0);

  always @(posedge clk) begin
    if (buf_we) bmem[buf_addr] <= buf_wdata;
    if (mem_req && mem_ack && mem_we) hmem[mem_addr[15:0]] <= mem_wdata;
    if (mem_req && mem_ack) begin nacc++; last_ma = mem_addr; end
    if (done_irq) nirq++;
    if (prev_pend && (!mem_req || mem_addr != prev_a)) nhold++;
    prev_pend = mem_req && !mem_ack;
    prev_a = mem_addr;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input bit w);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit w, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wide = w;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h98, 1'b1, v);
      if (!v[0]) break;
    end
  endtask

  function automatic void model(input logic [63:0] s, input logic [63:0] d,
                                input logic [63:0] n, input bit dir);
    for (int i = 0; i < 65536; i++) ehost[i] = hmem[i];
    for (int i = 0; i < 4096; i++) ebuf[i] = bmem[i];
    for (int i = 0; i < int'(n); i++) begin
      if (!dir) ebuf[12'(d - 64'h40000 + 64'(i))] = ehost[16'(s + 64'(i))];
      else      ehost[16'(d + 64'(i))] = ebuf[12'(s - 64'h40000 + 64'(i))];
    end
  endfunction

  function automatic int diffs();
    int e = 0;
    for (int i = 0; i < 65536; i++) if (hmem[i] !== ehost[i]) e++;
    for (int i = 0; i < 4096; i++) if (bmem[i] !== ebuf[i]) e++;
    return e;
  endfunction

  task automatic xfer(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                      input logic [2:0] cmd, input string tag);
    logic [63:0] v;
    int i0, e;
    model(s, d, n, cmd[1]);
    i0 = nirq;
    wr(8'h80, s, 1'b1); wr(8'h88, d, 1'b1); wr(8'h90, n, 1'b1);
    wr(8'h98, {61'd0, cmd}, 1'b1);
    rd(8'h98, 1'b1, v);
    if (n != 0) chk(v[0] == 1'b1, "R6 busy set", v, 64'h1);
    wait_idle();
    repeat (2) @(negedge clk);
    e = diffs();
    chk(e == 0, tag, e, 0);
    rd(8'h90, 1'b1, v); chk(v == 0, "R6 count zero", v, 0);
    rd(8'h80, 1'b1, v); chk(v == s + n, "R6 src advanced", v, s + n);
    rd(8'h88, 1'b1, v); chk(v == d + n, "R6 dst advanced", v, d + n);
    chk(nirq - i0 == int'(cmd[2]), "R7 irq count", nirq - i0, cmd[2]);
  endtask

  task automatic abort_case(input logic [63:0] d, input logic [63:0] n);
    logic [63:0] v;
    int a0, i0, e;
    model(64'h100, d, 0, 1'b0);
    a0 = nacc; i0 = nirq;
    wr(8'h80, 64'h100, 1'b1); wr(8'h88, d, 1'b1); wr(8'h90, n, 1'b1);
    wr(8'h98, 64'h5, 1'b1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(nacc == a0, "R10 no host access", nacc, a0);
    e = diffs(); chk(e == 0, "R10 no data moved", e, 0);
    rd(8'h90, 1'b1, v); chk(v == n, "R10 count kept", v, n);
    rd(8'h88, 1'b1, v); chk(v == d, "R10 dst kept", v, d);
    rd(8'h98, 1'b1, v); chk(v[0] == 1'b0, "R10 go cleared", v, 64'h4);
    chk(nirq == i0, "R10 no irq", nirq, i0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int a0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 65536; i++) hmem[i] = 8'($urandom);
    for (int i = 0; i < 4096; i++) bmem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h80 + 8*k), 1'b1, v);
      chk(v == 0, "R1 reg zero", v, 0);
    end
    chk(!mem_req && !done_irq, "R1 outputs low", {mem_req, done_irq}, 0);

    wr(8'h80, 64'h1122334455667788, 1'b1);
    rd(8'h80, 1'b1, v); chk(v == 64'h1122334455667788, "R2 wide rw", v, 64'h1122334455667788);
    rd(8'h84, 1'b0, v); chk(v == 64'h11223344, "R2 high half", v, 64'h11223344);
    wr(8'h80, 64'hAABBCCDD, 1'b0);
    rd(8'h80, 1'b1, v); chk(v == 64'h11223344AABBCCDD, "R2 half write", v, 64'h11223344AABBCCDD);
    wr(8'h98, 64'hFE, 1'b1);
    rd(8'h98, 1'b1, v); chk(v == 64'h6, "R2 cmd bits", v, 64'h6);

    wr(8'h84, 64'h0, 1'b1);
    rd(8'h80, 1'b1, v); chk(v == 64'h11223344AABBCCDD, "R3 misaligned wide", v, 64'h11223344AABBCCDD);
    wr(8'h82, 64'h0, 1'b0);
    rd(8'h80, 1'b1, v); chk(v == 64'h11223344AABBCCDD, "R3 unaligned", v, 64'h11223344AABBCCDD);
    rd(8'h40, 1'b1, v); chk(v == 0, "R3 low offset read", v, 0);
    rd(8'h84, 1'b1, v); chk(v == 0, "R3 misaligned read", v, 0);

    xfer(64'h0200, 64'h40000, 64'd100, 3'b101, "R4 to buffer");
    xfer(64'h40000, 64'h0264, 64'd100, 3'b011, "R5 to host");
    xfer(64'h0300, 64'h40FF0, 64'd16, 3'b001, "R10 exact fit");

    for (int t = 0; t < 10; t++) begin
      logic [63:0] n, h, dv;
      bit dir;
      n = 64'(1 + $urandom % 64);
      h = 64'($urandom % (65536 - 64));
      dv = 64'h40000 + 64'($urandom % (4096 - int'(n) + 1));
      dir = 1'($urandom);
      if (dir) xfer(dv, h, n, {1'($urandom), 2'b11}, "R5 random");
      else     xfer(h, dv, n, {1'($urandom), 2'b01}, "R4 random");
    end

    xfer(64'h1000_1200, 64'h40100, 64'd16, 3'b001, "R9 masked copy");
    chk(last_ma == 28'h000120F, "R9 low bits", last_ma, 28'h000120F);

    abort_case(64'h3FFFF, 64'd4);
    abort_case(64'h40FFC, 64'd5);

    a0 = nacc;
    xfer(64'h0500, 64'h40200, 64'd0, 3'b101, "R12 zero data");
    chk(nacc == a0, "R12 no host access", nacc, a0);

    stall = 1'b1;
    model(64'h0700, 64'h40400, 64'd8, 1'b0);
    wr(8'h80, 64'h0700, 1'b1); wr(8'h88, 64'h40400, 1'b1); wr(8'h90, 64'd8, 1'b1);
    wr(8'h98, 64'h1, 1'b1);
    wr(8'h90, 64'd99, 1'b1);
    wr(8'h80, 64'h0900, 1'b1);
    wr(8'h98, 64'h3, 1'b1);
    rd(8'h90, 1'b1, v); chk(v == 64'd8, "R11 count frozen", v, 8);
    rd(8'h98, 1'b1, v); chk(v == 64'h1, "R11 cmd frozen", v, 1);
    stall = 1'b0;
    wait_idle();
    repeat (2) @(negedge clk);
    a0 = diffs(); chk(a0 == 0, "R11 original copy", a0, 0);
    rd(8'h80, 1'b1, v); chk(v == 64'h0708, "R11 src", v, 64'h0708);

    chk(nhold == 0, "R8 request hold", nhold, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule